// File: doc/BRIEF.md
# Password-Guarded Windowed Watchdog

This block is a watchdog timer with a single 32-bit control register. Writes to the register are guarded by a two-step protocol. First, a write presents the current 14-bit password, and every other field in that write must repeat its present value. That write opens the register for exactly one modify write. A 16-bit counter counts up from a reload value. It advances once per prescaler step, and the prescaler divides a clock-enable tick by a slow or a fast divisor. When the counter passes its all-ones value, the watchdog has expired.

The register also holds an end-of-initialization bit, which is driven out on a pin for other logic to use. Clearing that bit opens a short unprotected window timed by a hardwired reload. Setting it again returns the counter to the software reload value. A missed service, a malformed write or an over-long window all move the block into a prewarning state. In that state it raises a non-maskable interrupt. After four further counter steps it raises a reset request that holds until the next hardware reset.

Top module: `pwd_wdt`

## Requirements
- R1: After reset, the register reads reload 0x0000, password PW_RST (default 0x1D3A), slow select 0 and end-of-init 0. The block starts in window mode with the count at 0xFFFC, and nmi_o and rst_req_o are low. With no writes, nmi_o rises on the 4*DIV_LO-th edge after reset release.
- R2: The register layout is [31:16] reload value, [15:2] password, [1] slow select, [0] end-of-init. rd_data_o always shows the current register, and endinit_o equals bit 0.
- R3: With slow select 0, the counter advances by one every DIV_LO ticks (default 256). With slow select 1, it advances every DIV_HI ticks (default 16384). The prescaler restarts whenever the counter is reloaded.
- R4: A write that arrives while the register is locked unlocks it for the next write only when [15:2] equals the password and [31:16], [1] and [0] equal their current values. Such a write changes no field. The next write after an unlock is the one modify write, and the write after that is checked as a locked write again.
- R5: A modify write loads all four fields and reloads the counter. If the new bit 0 is 1, the block enters normal mode and loads the written reload value. If bit 0 is 0, the block enters window mode and loads 0xFFFC.
- R6: A locked write with a wrong password or a mismatched guard field sends the block into prewarning on the edge that takes it, and leaves the register unchanged.
- R7: An overflow of the counter past 0xFFFF, in normal or window mode, sends the block into prewarning and raises nmi_o.
- R8: Entering prewarning reloads 0xFFFC. rst_req_o rises exactly 4 counter steps after nmi_o (4*DIV_LO ticks with slow select 0).
- R9: In prewarning, all writes are ignored. nmi_o stays high, and rst_req_o stays high once raised, until reset.
- R10: If a modify write arrives on the same edge as an expiry, the expiry wins: the block enters prewarning and the register keeps its old contents.
- R11: The password changes only through a modify write. A later unlock must use the new value, and the old value then counts as a wrong password.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock enable feeding the prescaler |
| wr_en_i | input | 1 | Register write strobe, one write per high cycle |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Current register contents |
| nmi_o | output | 1 | Non-maskable interrupt, prewarning active |
| rst_req_o | output | 1 | Reset request, sticky until reset |
| endinit_o | output | 1 | End-of-initialization protection bit |

## Verification
The assertions assume that wr_data_i carries known values whenever wr_en_i is high. They also assume that tick_i is never X, because the prescaler and counter step properties compare values across single edges. The bench holds tick_i high for the whole run, so every cycle counts as a tick. It drives each write for exactly one cycle at the falling edge, and it never leaves wr_en_i asserted across two edges by accident. The same-edge collision of an expiry with a modify write is produced on purpose by counting edges from reset release.

// File: rtl/pwd_wdt_pkg.sv
package pwd_wdt_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned PW_W  = 14;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_TOUT = 2'd1,
    MODE_PREW = 2'd2
  } wdt_mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [PW_W-1:0]  pw;
    logic             slow;
    logic             endinit;
  } wdt_ctrl_t;

  // all fields except the password must repeat the current contents
  function automatic logic guard_match(wdt_ctrl_t a, wdt_ctrl_t b);
    return (a.reload == b.reload) && (a.slow == b.slow) && (a.endinit == b.endinit);
  endfunction
endpackage

// File: rtl/pwd_wdt_presc.sv
module pwd_wdt_presc #(
  parameter int unsigned DIV_LO = 256,
  parameter int unsigned DIV_HI = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic slow_i,
  input  logic clr_i,
  output logic step_o
);
  localparam int unsigned DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int unsigned PC_W    = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last;

  assign last   = slow_i ? PC_W'(DIV_HI - 1) : PC_W'(DIV_LO - 1);
  // >= keeps a mid-count divisor switch from running past the new limit
  assign step_o = tick_i && (pc_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (clr_i)   pc_q <= '0;
    else if (tick_i)  pc_q <= step_o ? '0 : pc_q + 1'b1;
  end

  a_r3_step_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> (pc_q == '0));

  a_r3_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pc_q == '0));
endmodule

// File: rtl/pwd_wdt_cnt.sv
module pwd_wdt_cnt #(
  parameter int unsigned        CNT_W   = 16,
  parameter logic [CNT_W-1:0]   RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv   = step_i && !hold_i;
  assign ovf_o = adv && (cnt_q == '1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end

  a_r3_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !hold_i && !load_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r9_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwd_wdt_access.sv
module pwd_wdt_access
  import pwd_wdt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  wdt_ctrl_t wr_i,
  input  wdt_ctrl_t cur_i,
  input  logic      lock_i,
  output logic      mod_o,
  output logic      err_o
);
  logic armed_q;
  logic wr;
  logic key_ok;
  logic unl;

  assign wr     = wr_en_i && !lock_i;
  assign key_ok = (wr_i.pw == cur_i.pw) && guard_match(wr_i, cur_i);
  assign unl    = wr && !armed_q && key_ok;
  assign mod_o  = wr && armed_q;
  assign err_o  = wr && !armed_q && !key_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed_q <= 1'b0;
    else if (lock_i) armed_q <= 1'b0;
    else if (wr)     armed_q <= unl;
  end

  a_r4_single_modify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_o |=> !armed_q);

  a_r6_err_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !armed_q);
endmodule

// File: rtl/pwd_wdt.sv
module pwd_wdt
  import pwd_wdt_pkg::*;
#(
  parameter int unsigned      DIV_LO = 256,
  parameter int unsigned      DIV_HI = 16384,
  parameter logic [PW_W-1:0]  PW_RST = 14'h1D3A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        nmi_o,
  output logic        rst_req_o,
  output logic        endinit_o
);
  localparam logic [CNT_W-1:0] FIXED_RLD = ~CNT_W'(3);

  wdt_ctrl_t        ctrl_q;
  wdt_ctrl_t        wr_ctrl;
  wdt_mode_e        mode_q;
  logic             rst_req_q;
  logic             prew;
  logic             acc_mod;
  logic             acc_err;
  logic             expire;
  logic             fault;
  logic             take_mod;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             step;
  logic [CNT_W-1:0] cnt;

  assign wr_ctrl  = wdt_ctrl_t'(wr_data_i);
  assign prew     = (mode_q == MODE_PREW);
  assign fault    = !prew && (acc_err || expire);
  assign take_mod = !prew && acc_mod && !expire;
  assign load     = fault || take_mod;
  assign load_val = (take_mod && wr_ctrl.endinit) ? wr_ctrl.reload : FIXED_RLD;

  pwd_wdt_access i_access (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wr_i    (wr_ctrl),
    .cur_i   (ctrl_q),
    .lock_i  (prew),
    .mod_o   (acc_mod),
    .err_o   (acc_err)
  );

  pwd_wdt_presc #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .slow_i (ctrl_q.slow),
    .clr_i  (load),
    .step_o (step)
  );

  pwd_wdt_cnt #(.CNT_W(CNT_W), .RST_VAL(FIXED_RLD)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (step),
    .hold_i     (rst_req_q),
    .cnt_o      (cnt),
    .ovf_o      (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '{reload: '0, pw: PW_RST, slow: 1'b0, endinit: 1'b0};
      mode_q    <= MODE_TOUT;
      rst_req_q <= 1'b0;
    end else begin
      if (fault) begin
        mode_q <= MODE_PREW;
      end else if (take_mod) begin
        ctrl_q <= wr_ctrl;
        mode_q <= wr_ctrl.endinit ? MODE_NORM : MODE_TOUT;
      end
      if (prew && expire) rst_req_q <= 1'b1;
    end
  end

  assign rd_data_o = ctrl_q;
  assign nmi_o     = prew;
  assign rst_req_o = rst_req_q;
  assign endinit_o = ctrl_q.endinit;

  a_r7_nmi_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> nmi_o);

  a_r9_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  a_r8_rst_after_nmi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> nmi_o);

  a_r6_bad_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err |=> (nmi_o && $stable(ctrl_q)));

  a_r9_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prew |=> $stable(ctrl_q));

  a_r10_expire_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && acc_mod && !prew) |=> (nmi_o && $stable(ctrl_q)));

  a_r11_pw_only_modify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_mod |=> $stable(ctrl_q.pw));

  a_r5_window_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_mod && !wr_ctrl.endinit) |=> (cnt == FIXED_RLD));

  a_r5_normal_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_mod && wr_ctrl.endinit) |=> (cnt == $past(wr_ctrl.reload)));
endmodule

// File: tb/test_pwd_wdt.sv
module test_pwd_wdt;
  localparam int unsigned DIV_LO = 8;
  localparam int unsigned DIV_HI = 32;
  localparam logic [13:0] PW0    = 14'h1D3A;
  localparam logic [13:0] PW1    = 14'h0155;
  localparam int          NVEC   = 6;
  // {expect nmi after one locked write from reset, write word}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_74E8},   // correct key and guards
    {1'b1, 32'h0000_74EC},   // password off by one
    {1'b1, 32'h0001_74E8},   // reload guard mismatch
    {1'b1, 32'h0000_74EA},   // slow-select guard mismatch
    {1'b1, 32'h0000_74E9},   // end-of-init guard mismatch
    {1'b1, 32'h0000_0000}    // all zero
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        nmi, rst_req, endinit;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  pwd_wdt #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .PW_RST(PW0)) i_pwd_wdt (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .nmi_o     (nmi),
    .rst_req_o (rst_req),
    .endinit_o (endinit)
  );

  function automatic logic [31:0] word(logic [15:0] rld, logic [13:0] pw, logic slow, logic ei);
    return {rld, pw, slow, ei};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic svc(input logic [31:0] cur, input logic [31:0] nxt);
    wr(cur);
    wr(nxt);
  endtask

  task automatic count_until(input bit want_rst, input int max, output int n);
    n = 0;
    while (!(want_rst ? rst_req : nmi) && n < max) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(20ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] nrm;
    nrm = word(16'hFFF0, PW0, 1'b0, 1'b1);

    // vector table: one locked write from reset (R4, R6)
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(VEC[i][31:0]);
      chk($sformatf("R6 vec%0d nmi", i), {31'b0, nmi}, {31'b0, VEC[i][32]});
      chk($sformatf("R4 vec%0d reg unchanged", i), rd_data, 32'h0000_74E8);
    end

    // R1 reset state and the window that runs from reset
    do_reset();
    chk("R1 reg", rd_data, 32'h0000_74E8);
    chk("R1 outs", {29'b0, nmi, rst_req, endinit}, 32'h0);
    repeat (20) @(negedge clk);
    chk("R1 no nmi early", {31'b0, nmi}, 32'h0);
    repeat (20) @(negedge clk);
    chk("R1 window from reset", {31'b0, nmi}, 32'h1);

    // R5/R2 good service, repeated well inside the 128-cycle period
    do_reset();
    svc(32'h0000_74E8, nrm);
    chk("R2 readback", rd_data, nrm);
    chk("R5 endinit pin", {31'b0, endinit}, 32'h1);
    for (int k = 0; k < 5; k++) begin
      repeat (100) @(negedge clk);
      svc(nrm, nrm);
      chk($sformatf("R5 service %0d no nmi", k), {31'b0, nmi}, 32'h0);
    end

    // R7 late service: 16 steps of 8; R8 then 4 steps of 8
    count_until(1'b0, 1000, n);
    chk("R7 expiry cycles", n, 128);
    count_until(1'b1, 1000, n);
    chk("R8 nmi to reset cycles", n, 32);
    repeat (50) @(negedge clk);
    chk("R9 reset held", {30'b0, nmi, rst_req}, 32'h3);
    svc(nrm, word(16'h1234, PW0, 1'b0, 1'b1));
    chk("R9 writes ignored", rd_data, nrm);

    // R5 window: clearing end-of-init times out after 4 steps
    do_reset();
    svc(32'h0000_74E8, nrm);
    svc(nrm, word(16'hFFF0, PW0, 1'b0, 1'b0));
    chk("R5 endinit cleared", {31'b0, endinit}, 32'h0);
    count_until(1'b0, 1000, n);
    chk("R5 window cycles", n, 32);

    // R3 slow divisor
    do_reset();
    svc(32'h0000_74E8, word(16'h0000, PW0, 1'b1, 1'b0));
    count_until(1'b0, 1000, n);
    chk("R3 slow window cycles", n, 128);

    // R6 bad password in normal mode, then prewarning to reset
    do_reset();
    svc(32'h0000_74E8, nrm);
    wr(word(16'hFFF0, 14'h1D3B, 1'b0, 1'b1));
    chk("R6 nmi", {31'b0, nmi}, 32'h1);
    chk("R6 reg kept", rd_data, nrm);
    count_until(1'b1, 1000, n);
    chk("R8 reset after bad write", n, 32);

    // R4 the write after a modify is locked again
    do_reset();
    svc(32'h0000_74E8, nrm);
    wr(word(16'hFF00, PW0, 1'b0, 1'b1));
    chk("R4 second modify rejected", {31'b0, nmi}, 32'h1);
    chk("R4 reg kept", rd_data, nrm);

    // R11 password change
    do_reset();
    svc(32'h0000_74E8, word(16'hFFF0, PW1, 1'b0, 1'b1));
    chk("R11 new pw readback", rd_data, word(16'hFFF0, PW1, 1'b0, 1'b1));
    svc(word(16'hFFF0, PW1, 1'b0, 1'b1), word(16'hFFF0, PW1, 1'b0, 1'b1));
    chk("R11 new pw accepted", {31'b0, nmi}, 32'h0);
    wr(word(16'hFFF0, PW0, 1'b0, 1'b1));
    chk("R11 old pw rejected", {31'b0, nmi}, 32'h1);

    // R10 modify lands on the expiry edge (edge 32 after release)
    do_reset();
    repeat (28) @(negedge clk);
    svc(32'h0000_74E8, nrm);
    chk("R10 expiry wins nmi", {31'b0, nmi}, 32'h1);
    chk("R10 reg kept", rd_data, 32'h0000_74E8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule